// File: doc/BRIEF.md
# UART Fractional Baud Rate Generator

This block produces the 16x oversampling enable that a UART receiver and transmitter use as their sample clock. It runs from the peripheral clock and divides it in two stages. An integer counter first divides by a 16-bit divisor. A fractional stage then drops some of those divisor periods, so that the average tick period becomes `divisor × (1 + add/mul)` peripheral clock cycles. The resulting tick rate is `pclk / (16 × divisor × (1 + add/mul))` measured at the bit level. When `add` is zero the fractional stage does nothing and the rate is `pclk / (16 × divisor)`.

Software programs the block through a byte-wide register port with four addresses. The two divisor bytes can be reached only while the top bit of the line setup register is set. Any write that changes the divisor or the fraction restarts the divider from a known phase.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset the registers read back as follows. The fraction register (address 2) reads 0x10, which is mul = 1 and add = 0. The line setup register (address 3) reads 0x00. Once the latch bit is set, divisor low (address 0) reads 0x01 and divisor high (address 1) reads 0x00.
- R2: The divisor low and high bytes sit at addresses 0 and 1. They can be reached only while bit 7 of the line setup register is 1. While that bit is 0, writes to addresses 0 and 1 leave the divisor and the tick period unchanged, and reads from those addresses return 0x00.
- R3: The line setup register at address 3 stores all 8 written bits and reads them back. For example, 0x83 turns latch access on and 0x03 turns it off.
- R4: The fraction register at address 2 holds mul in bits 7:4 and add in bits 3:0. It reads back exactly as written.
- R5: With add = 0 and a divisor D of 2 or more, `tick` is a single-cycle pulse that repeats exactly every D clock cycles. This includes divisors that use the high byte.
- R6: A divisor of 0 behaves like a divisor of 1: with add = 0, `tick` is high on every cycle.
- R7: With a fractional setting, the number of ticks in a window of N cycles is within one of floor(N × mul / (D × (mul + add))).
- R8: When add < mul, the gap between consecutive ticks is always either D or 2D cycles.
- R9: An accepted write to either divisor byte, or to the fraction register, restarts the divider. `tick` is low in the next cycle. With add = 0, the first tick appears D cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 divisor low, 1 divisor high, 2 fraction, 3 line setup) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick | output | 1 | 16x oversampling enable, one cycle wide |

## Verification
The bench builds the block with its default widths: 8-bit register bytes and a 4-bit fractional field. With these widths the divisor is 16 bits, so a divisor of 300 exercises the high byte and the latch gating of both bytes. The 4-bit fields let the bench try fraction settings up to mul = 15 with a large add, such as 15 and 7, as well as small ratios such as 2 and 1 and 4 and 1. Counting ticks over windows of several thousand cycles compares the long-run rate with the formula, and the gap between ticks is checked along the way.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Register addresses seen on the byte port
    typedef enum logic [1:0] {
        ADDR_DIV_LO = 2'd0,
        ADDR_DIV_HI = 2'd1,
        ADDR_FRAC   = 2'd2,
        ADDR_LINE   = 2'd3
    } baud_addr_e;

endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wen_i,
    input  logic [1:0]            addr_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    output logic [BYTE_W-1:0]     rdata_o,
    output logic [2*BYTE_W-1:0]   div_o,
    output logic [FRAC_W-1:0]     mul_o,
    output logic [FRAC_W-1:0]     add_o,
    output logic [BYTE_W-1:0]     line_o,
    output logic                  restart_o
);
    localparam int FR_W  = 2 * FRAC_W;
    localparam int LATCH = BYTE_W - 1;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] line;
        logic [FR_W-1:0]   frac;
    } regs_t;

    regs_t r_d, r_q;
    logic  latch_on;

    always_comb begin
        r_d       = r_q;
        restart_o = 1'b0;
        latch_on  = r_q.line[LATCH];
        rdata_o   = '0;

        case (baud_addr_e'(addr_i))
            ADDR_DIV_LO: if (latch_on) rdata_o = r_q.lo;
            ADDR_DIV_HI: if (latch_on) rdata_o = r_q.hi;
            ADDR_FRAC:   rdata_o = BYTE_W'(r_q.frac);
            default:     rdata_o = r_q.line;
        endcase

        if (wen_i) begin
            case (baud_addr_e'(addr_i))
                ADDR_DIV_LO: if (latch_on) begin
                    r_d.lo    = wdata_i;
                    restart_o = 1'b1;
                end
                ADDR_DIV_HI: if (latch_on) begin
                    r_d.hi    = wdata_i;
                    restart_o = 1'b1;
                end
                ADDR_FRAC: begin
                    r_d.frac  = wdata_i[FR_W-1:0];
                    restart_o = 1'b1;
                end
                default: r_d.line = wdata_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.lo   <= BYTE_W'(1);
            r_q.hi   <= '0;
            r_q.line <= '0;
            r_q.frac <= FR_W'(1) << FRAC_W;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_o  = {r_q.hi, r_q.lo};
    assign mul_o  = r_q.frac[FR_W-1:FRAC_W];
    assign add_o  = r_q.frac[FRAC_W-1:0];
    assign line_o = r_q.line;

endmodule

// File: rtl/baud_divcnt.sv
module baud_divcnt #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             pulse_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } cnt_t;

    cnt_t             s_d, s_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        // a divisor of zero counts like one
        last    = (div_i == '0) ? '0 : div_i - DIV_W'(1);
        pulse_o = (s_q.cnt == last) && !restart_i;
        s_d     = s_q;
        if (restart_i || pulse_o) s_d.cnt = '0;
        else                      s_d.cnt = s_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/baud_fracacc.sv
module baud_fracacc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    input  logic              restart_i,
    input  logic [FRAC_W-1:0] mul_i,
    input  logic [FRAC_W-1:0] add_i,
    output logic              tick_o
);
    localparam int ACC_W = FRAC_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } frac_t;

    frac_t            s_d, s_q;
    logic [ACC_W-1:0] mul_eff, limit, sum;

    always_comb begin
        mul_eff = (mul_i == '0) ? ACC_W'(1) : ACC_W'(mul_i);
        limit   = mul_eff + ACC_W'(add_i);
        sum     = s_q.acc + mul_eff;
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (restart_i) begin
            s_d.acc = '0;
        end else if (pulse_i) begin
            // emit mul ticks for every mul+add divisor periods
            if (sum >= limit) begin
                s_d.acc  = sum - limit;
                s_d.tick = 1'b1;
            end else begin
                s_d.acc  = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              tick
);
    localparam int DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0]  div_w;
    logic [FRAC_W-1:0] mul_w, add_w;
    logic [BYTE_W-1:0] line_w;
    logic              restart_w, pulse_w;

    baud_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen_i     (reg_wen),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .div_o     (div_w),
        .mul_o     (mul_w),
        .add_o     (add_w),
        .line_o    (line_w),
        .restart_o (restart_w)
    );

    baud_divcnt #(.DIV_W(DIV_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (div_w),
        .restart_i (restart_w),
        .pulse_o   (pulse_w)
    );

    baud_fracacc #(.FRAC_W(FRAC_W)) u_frac (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_i   (pulse_w),
        .restart_i (restart_w),
        .mul_i     (mul_w),
        .add_i     (add_w),
        .tick_o    (tick)
    );

endmodule

// File: rtl/baud_frac_chk.sv
module baud_frac_chk #(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wen,
    input logic [1:0]          reg_addr,
    input logic [BYTE_W-1:0]   reg_wdata,
    input logic [2*BYTE_W-1:0] div_w,
    input logic [FRAC_W-1:0]   mul_w,
    input logic [FRAC_W-1:0]   add_w,
    input logic [BYTE_W-1:0]   line_w,
    input logic                restart_w,
    input logic                tick
);
    // R2
    div_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr[1] == 1'b0 && !line_w[BYTE_W-1]) |=> $stable(div_w));

    // R3
    line_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 2'd3) |=> (line_w == $past(reg_wdata)));

    // R4
    frac_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 2'd2) |=> ({mul_w, add_w} == $past(reg_wdata[2*FRAC_W-1:0])));

    // R9
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_w |=> !tick);

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_w > 2*BYTE_W'(1)) |=> !tick);

endmodule

bind baud_frac_gen baud_frac_chk #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .div_w     (div_w),
    .mul_w     (mul_w),
    .add_w     (add_w),
    .line_w    (line_w),
    .restart_w (restart_w),
    .tick      (tick)
);

// File: tb/sim_baud_frac_gen.sv
`timescale 1ns/1ps
module sim_baud_frac_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wen = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tick;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    typedef struct {
        int    val;
        string req;
    } rd_item_t;
    rd_item_t exp_q[$];

    always #2.5 clk = ~clk;

    baud_frac_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the expected read value and compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                rd_item_t it;
                it = exp_q.pop_front();
                chk(reg_rdata == it.val[7:0], it.req, reg_rdata, it.val);
            end
        end
    end

    task automatic rd_expect(input int a, input int v, input string req);
        rd_item_t it;
        @(negedge clk);
        reg_addr = a[1:0];
        it.val = v;
        it.req = req;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wen   = 1'b1;
        reg_addr  = a[1:0];
        reg_wdata = d[7:0];
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic cfg(input int lo, input int hi, input int fr);
        wr(3, 8'h83);
        wr(0, lo);
        wr(1, hi);
        wr(2, fr);
    endtask

    // cycles between two consecutive ticks
    task automatic gap(output int g);
        int k = 0;
        do @(negedge clk); while (!tick);
        do begin @(negedge clk); k++; end while (!tick);
        g = k;
    endtask

    task automatic window(input int d, input int m, input int a, input int n, input string req);
        int cnt = 0;
        int expv;
        int lastt = -1;
        int bad = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (tick) begin
                cnt++;
                if (lastt >= 0 && (i - lastt) != d && (i - lastt) != 2 * d) bad++;
                lastt = i;
            end
        end
        expv = (n * m) / (d * (m + a));
        chk(cnt >= expv - 1 && cnt <= expv + 1, req, cnt, expv);
        // R8 gap is D or 2D
        chk(bad == 0, "R8", bad, 0);
    endtask

    initial begin
        int g;
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_expect(2, 8'h10, "R1");
        rd_expect(3, 8'h00, "R1");
        // R6 reset divisor is 1: tick on every cycle
        gap(g);
        chk(g == 1, "R6", g, 1);
        wr(3, 8'h83);
        rd_expect(0, 8'h01, "R1");
        rd_expect(1, 8'h00, "R1");
        // R3 line register readback
        rd_expect(3, 8'h83, "R3");

        // R2 divisor bytes gated by latch bit
        wr(0, 5);
        wr(1, 0);
        rd_expect(0, 5, "R2");
        wr(3, 8'h03);
        rd_expect(3, 8'h03, "R3");
        wr(0, 8'h77);
        wr(1, 8'h12);
        rd_expect(0, 0, "R2");
        rd_expect(1, 0, "R2");
        gap(g);
        chk(g == 5, "R2", g, 5);
        wr(3, 8'h83);
        rd_expect(0, 5, "R2");
        rd_expect(1, 0, "R2");

        // R4 fraction field layout
        wr(2, 8'h4A);
        rd_expect(2, 8'h4A, "R4");

        // R5 exact period with add = 0
        wr(2, 8'h10);
        for (int i = 0; i < 3; i++) begin
            gap(g);
            chk(g == 5, "R5", g, 5);
        end
        do @(negedge clk); while (!tick);
        @(negedge clk);
        chk(tick == 1'b0, "R5", tick, 0);

        // R9 restart phase: first tick D cycles after write edge
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 2'd0; reg_wdata = 8'd7;
        @(posedge clk);
        @(negedge clk);
        reg_wen = 1'b0;
        k = 0;
        chk(tick == 1'b0, "R9", tick, 0);
        do begin @(posedge clk); k++; @(negedge clk); end while (!tick && k < 50);
        chk(k == 7, "R9", k, 7);

        // R6 divisor zero acts as one
        cfg(0, 0, 8'h10);
        k = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tick) k++;
        end
        chk(k == 10, "R6", k, 10);

        // R5 with the high byte: D = 300
        cfg(44, 1, 8'h10);
        gap(g);
        chk(g == 300, "R5", g, 300);

        // R7 fractional rates
        cfg(5, 0, 8'h41);
        window(5, 4, 1, 5000, "R7");
        cfg(3, 0, 8'hF7);
        window(3, 15, 7, 6600, "R7");
        cfg(2, 0, 8'h21);
        window(2, 2, 1, 3000, "R7");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule